// File: doc/BRIEF.md
# Compare Match Interval Timer

A single-channel periodic timer. A free-running prescaler divides the main clock by one of four power-of-two ratios and turns out a one-cycle enable pulse at that rate. An up-counter advances on each pulse while the run bit is set. When the counter equals a programmable limit on a pulse, the counter returns to zero and a sticky match flag is raised. The interval between matches is therefore (limit + 1) pulses.

Software reaches the control bits, the counter and the limit through a small synchronous bus. The bus has a two-bit address, a write strobe, write data and combinational read data. The match flag can only be cleared by writing zero to it. A hardware match in the same cycle as a clear takes priority, so no event is lost. Both the synchronous active-low reset and a standby input return every register to its initial value.

The ratio for select code s is 2^(PRE_BASE_LOG2 + PRE_STEP_LOG2*s). The defaults give ratios of 8, 32, 128 and 512 for codes 00, 01, 10 and 11.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0 (run bit 0, select 00, flag 0), the counter reads 0 and the limit reads all ones.
- R2: While `standby` is high, all registers are forced to their reset values on each clock, and bus writes have no effect.
- R3: With select code s, the counter advances once every 2^(PRE_BASE_LOG2 + PRE_STEP_LOG2*s) clock cycles (8, 32, 128 or 512 with the defaults).
- R4: With the run bit at 0 the counter holds its value and is not reset.
- R5: Setting the run bit restarts the prescaler from zero: the first advance comes one full ratio after the write edge, never sooner.
- R6: On an advance where the counter equals the limit, the counter becomes 0 and the flag becomes 1, so matches repeat every (limit + 1) advances.
- R7: Writing 0 to flag bit 3 of the control register clears the flag; writing 1 there leaves it unchanged.
- R8: If a match and a flag-clearing write happen in the same cycle, the flag ends up set.
- R9: With a limit of 0, every advance is a match and the counter stays at 0.
- R10: Address 0 is control (bit 0 run, bits 2:1 select, bit 3 flag), address 1 is the counter, address 2 is the limit and address 3 reads 0. Writes take effect at the next edge, and reads return the current values.
- R11: A counter above the limit keeps counting up, wraps from all ones to 0 without setting the flag, and matches later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Holds all registers at their reset values while high |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |

## Verification
The bench builds the block with CNT_W = 8, PRE_BASE_LOG2 = 1 and PRE_STEP_LOG2 = 1, which gives ratios of 2, 4, 8 and 16. At these values the reset-value limit of all ones, the wrap from 0xFF to 0 and the spacing of all four ratios can each be reached in a few hundred cycles. A fixed cycle offset between a match and a clearing write lets the bench land both on the same edge. Random limits and tick counts are then compared against a modulo model of the count and the flag.

// File: rtl/cmt_pkg.sv
// Shared register map and bit positions for the interval timer.
// Assumes a two-bit register address and data at least four bits wide.
package cmt_pkg;
    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_LIMIT = 2'd2;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_SEL_LO = 1;
    localparam int CTRL_FLAG   = 3;

    typedef struct packed {
        logic [1:0] sel;
        logic       run;
    } ctrl_t;
endpackage

// File: rtl/cmt_prescaler.sv
// Free-running clock divider that emits a one-cycle enable pulse at the
// ratio chosen by a two-bit code: 2^(BASE + STEP*code).
// Assumes BASE >= 1. The divider is held at zero while run is low, so a
// restart always waits a full ratio before the first pulse.
module cmt_prescaler #(
    parameter int BASE = 3,
    parameter int STEP = 2,
    localparam int DIV_W = BASE + 3 * STEP
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask [4];

    // One low-bits mask per select code.
    for (genvar g = 0; g < 4; g++) begin : g_mask
        assign mask[g] = {DIV_W{1'b1}} >> (DIV_W - (BASE + STEP * g));
    end

    // Divider: counts while running, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // Pulse when the selected low bits are all ones.
    assign tick = run && ((div_q & mask[sel]) == mask[sel]);

    p_no_tick_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !tick);
endmodule

// File: rtl/cmt_counter.sv
// Up-counter with clear on match. It advances on tick, reloads from the
// bus and is forced to zero in standby. It reports a match (hit) when a tick
// arrives while the count equals the limit.
// Assumes tick is a single-cycle enable in the same clock domain.
module cmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic         tick,
    input  logic [W-1:0] limit,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = tick && !standby && (cnt_q == limit);
    assign cnt = cnt_q;

    // Count register: init, bus load, clear on match, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) cnt_q <= '0;
        else if (wr_en)        cnt_q <= wr_data;
        else if (hit)          cnt_q <= '0;
        else if (tick)         cnt_q <= cnt_q + 1'b1;
    end

    p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en && !standby) |=> $stable(cnt_q));
    p_standby_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (cnt_q == '0));
    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !standby && !wr_en && (cnt_q != limit)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cmt_regs.sv
// Register file for the timer: control (run, select), limit and the sticky
// match flag, plus the read mux. Hardware set of the flag beats a
// software clear. Standby and reset restore initial values.
// Assumes W >= 4.
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic [1:0]   addr,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    input  logic         hit,
    output logic         run,
    output logic [1:0]   sel,
    output logic [W-1:0] limit,
    output logic         cnt_wr,
    output logic [W-1:0] rdata
);
    ctrl_t        ctrl_q;
    logic [W-1:0] limit_q;
    logic         flag_q;
    logic         wr_ctrl;
    logic         wr_limit;

    assign wr_ctrl  = we && !standby && (addr == ADDR_CTRL);
    assign wr_limit = we && !standby && (addr == ADDR_LIMIT);
    assign cnt_wr   = we && !standby && (addr == ADDR_COUNT);

    // Control register: run bit and ratio select.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) ctrl_q <= '0;
        else if (wr_ctrl) begin
            ctrl_q.run <= wdata[CTRL_RUN];
            ctrl_q.sel <= wdata[CTRL_SEL_LO +: 2];
        end
    end

    // Limit register, initialised to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) limit_q <= '1;
        else if (wr_limit)     limit_q <= wdata;
    end

    // Match flag: set by hardware, cleared only by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n || standby)               flag_q <= 1'b0;
        else if (hit)                        flag_q <= 1'b1;
        else if (wr_ctrl && !wdata[CTRL_FLAG]) flag_q <= 1'b0;
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[CTRL_RUN]          = ctrl_q.run;
                rdata[CTRL_SEL_LO +: 2]  = ctrl_q.sel;
                rdata[CTRL_FLAG]         = flag_q;
            end
            ADDR_COUNT: rdata = cnt;
            ADDR_LIMIT: rdata = limit_q;
            default:    rdata = '0;
        endcase
    end

    assign run   = ctrl_q.run;
    assign sel   = ctrl_q.sel;
    assign limit = limit_q;

    p_flag_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);
    p_flag_w1_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTRL_FLAG] && !hit) |=> $stable(flag_q));
    p_standby_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (limit_q == '1 && !ctrl_q.run && ctrl_q.sel == 2'b00 && !flag_q));
endmodule

// File: rtl/interval_timer.sv
// Top of the compare match interval timer: prescaler, counter and
// register file. Single clock domain, synchronous active-low reset.
module interval_timer #(
    parameter int CNT_W         = 16,
    parameter int PRE_BASE_LOG2 = 3,
    parameter int PRE_STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata
);
    logic             run;
    logic [1:0]       sel;
    logic             tick;
    logic             hit;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    cmt_prescaler #(.BASE(PRE_BASE_LOG2), .STEP(PRE_STEP_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .tick(tick)
    );

    cmt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .standby(standby), .tick(tick),
        .limit(limit), .wr_en(cnt_wr), .wr_data(bus_wdata),
        .cnt(cnt), .hit(hit)
    );

    cmt_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .standby(standby), .addr(bus_addr),
        .we(bus_we), .wdata(bus_wdata), .cnt(cnt), .hit(hit),
        .run(run), .sel(sel), .limit(limit), .cnt_wr(cnt_wr),
        .rdata(bus_rdata)
    );
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    localparam int W = 8;
    localparam int BASE = 1;
    localparam int STEP = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         standby = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    interval_timer #(.CNT_W(W), .PRE_BASE_LOG2(BASE), .PRE_STEP_LOG2(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    function automatic int ratio(input int s);
        return 1 << (BASE + STEP * s);
    endfunction
    function automatic int exp_count(input int ticks, input int lim);
        return ticks % (lim + 1);
    endfunction
    function automatic int exp_flag(input int ticks, input int lim);
        return (ticks > lim) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = W'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic rd_flag(output int f);
        int v;
        rd(2'd0, v);
        f = (v >> 3) & 1;
    endtask

    // Stop, clear flag, load count and limit; then start with code s.
    task automatic arm(input int s, input int c0, input int lim);
        wr(2'd0, 0);
        wr(2'd1, c0);
        wr(2'd2, lim);
        wr(2'd0, 8 | (s << 1) | 1);
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, f, held, dummy;
        dummy = $urandom(32'h5eed);
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        rd(2'd0, v); check("R1", "ctrl", v, 0);
        rd(2'd1, v); check("R1", "count", v, 0);
        rd(2'd2, v); check("R1", "limit", v, 8'hFF);
        // R10 unused address
        rd(2'd3, v); check("R10", "addr3", v, 0);

        // R3/R5 ratio and first-advance timing, R4 hold on stop
        for (int s = 0; s < 4; s++) begin
            arm(s, 0, 8'hFF);
            wait_n(ratio(s) - 1);
            rd(2'd1, v); check("R5", $sformatf("before first tick s=%0d", s), v, 0);
            wait_n(1);
            rd(2'd1, v); check("R3", $sformatf("first tick s=%0d", s), v, 1);
            wait_n(5 * ratio(s));
            rd(2'd1, v); check("R3", $sformatf("six ticks s=%0d", s), v, 6);
            wr(2'd0, 8 | (s << 1));
            rd(2'd1, held);
            check("R4", "not reset on stop", (held >= 6) ? 1 : 0, 1);
            wait_n(3 * ratio(s));
            rd(2'd1, v); check("R4", "held while stopped", v, held);
        end

        // R6 match and clear, period limit+1
        arm(0, 0, 3);
        wait_n(3 * ratio(0));
        rd(2'd1, v); check("R6", "count before match", v, 3);
        rd_flag(f);  check("R6", "flag before match", f, 0);
        wait_n(ratio(0));
        rd(2'd1, v); check("R6", "count after match", v, 0);
        rd_flag(f);  check("R6", "flag after match", f, 1);
        wait_n(ratio(0));
        rd(2'd1, v); check("R6", "count restarts", v, 1);

        // R7 flag write 1 keeps, write 0 clears, write 1 does not set
        wr(2'd0, 8);
        rd_flag(f); check("R7", "write 1 keeps flag", f, 1);
        wr(2'd0, 0);
        rd_flag(f); check("R7", "write 0 clears flag", f, 0);
        wr(2'd0, 8);
        rd_flag(f); check("R7", "write 1 does not set", f, 0);

        // R8 set beats clear on the same edge; R9 limit zero
        arm(0, 0, 0);
        wr(2'd0, 1);  // write edge = start edge + 2 = a tick with match
        rd_flag(f); check("R8", "set wins over clear", f, 1);
        rd(2'd1, v); check("R9", "count stays zero", v, 0);
        wait_n(9);
        rd(2'd1, v); check("R9", "count zero after many ticks", v, 0);
        rd_flag(f); check("R9", "flag set by zero limit", f, 1);

        // R11 wrap past all ones without flag, then match
        arm(0, 8'hFD, 5);
        wait_n(3 * ratio(0));
        rd(2'd1, v); check("R11", "wrapped to zero", v, 0);
        rd_flag(f);  check("R11", "no flag on wrap", f, 0);
        wait_n(6 * ratio(0));
        rd(2'd1, v); check("R11", "match after wrap", v, 0);
        rd_flag(f);  check("R11", "flag after wrap match", f, 1);

        // R2 standby restores and blocks writes
        arm(1, 0, 8'h55);
        wait_n(5);
        @(negedge clk);
        standby = 1'b1;
        wr(2'd2, 8'h12);
        wr(2'd0, 1);
        rd(2'd0, v); check("R2", "ctrl in standby", v, 0);
        rd(2'd1, v); check("R2", "count in standby", v, 0);
        rd(2'd2, v); check("R2", "limit in standby", v, 8'hFF);
        @(negedge clk);
        standby = 1'b0;
        wait_n(20);
        rd(2'd1, v); check("R2", "count stays after standby", v, 0);

        // R10 random read-back of limit and count
        for (int i = 0; i < 8; i++) begin
            int d;
            d = int'($urandom_range(0, 255));
            wr(2'd2, d);
            rd(2'd2, v); check("R10", "limit readback", v, d);
            d = int'($urandom_range(0, 255));
            wr(2'd1, d);
            rd(2'd1, v); check("R10", "count readback", v, d);
        end

        // R3/R6 random periods against the modulo model
        for (int i = 0; i < 20; i++) begin
            int s, lim, t;
            s   = int'($urandom_range(0, 3));
            lim = int'($urandom_range(0, 7));
            t   = int'($urandom_range(1, 24));
            arm(s, 0, lim);
            wait_n(t * ratio(s));
            rd(2'd1, v); check("R6", $sformatf("rand count s=%0d l=%0d t=%0d", s, lim, t), v, exp_count(t, lim));
            rd_flag(f);  check("R6", $sformatf("rand flag s=%0d l=%0d t=%0d", s, lim, t), f, exp_flag(t, lim));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule